// File: doc/BRIEF.md
# Paged Address Generator with Field Extension

This block forms physical word addresses for a 12-bit accumulator processor whose memory is split into 4096-word fields. A data reference names a location with a 7-bit in-page offset and a page-select bit. The base is either page zero or the page that holds the program counter. A 3-bit field value then chooses one of eight banks, which gives a 15-bit physical address. Instruction fetches use the program counter directly, under the instruction field. Data accesses use the effective address, under the data field.

The field registers are controlled by the processor's decoder through strobes. A new instruction field is written into a pending register, and it takes effect only at the next executed jump or call. This lets a program finish the instructions that come before the transfer in its old bank. A data field write takes effect at once for later data accesses. When an interrupt is acknowledged, both fields are saved and then cleared, so the handler runs in field 0. A restore strobe puts the saved values back: the data field is reloaded directly, and the instruction field is reloaded into the pending register, where it waits for the handler's return jump.

Top module: `pg_addr_gen`

## Requirements
- R1: After reset, `if_o` and `df_o` are 0, `addr_valid_o` is low, and the pending and saved fields are 0.
- R2: On a data access with `page_sel_i`=0, address bits [11:7] are 0 and bits [6:0] equal `offset_i`.
- R3: On a data access with `page_sel_i`=1, address bits [11:7] equal `pc_i[11:7]` and bits [6:0] equal `offset_i`.
- R4: The field in address bits [14:12] is the instruction field for a fetch (`fetch_i`=1), and then bits [11:0] equal `pc_i`. For a data access (`fetch_i`=0) it is the data field. In both cases the field value used is the one held in the request cycle.
- R5: `addr_o` is registered. `addr_valid_o` is high in the cycle after a cycle with `req_i` high, and low after a cycle with `req_i` low.
- R6: `df_we_i` loads `df_wdata_i` into the data field. A data access in the same cycle still uses the old value, and accesses in later cycles use the new one.
- R7: `if_we_i` loads only the pending instruction field. `if_o` and the field used for fetches do not change until a jump.
- R8: `jump_i` copies the pending field, as it was before that cycle, into the instruction field on the next cycle.
- R9: `int_ack_i` saves the instruction field and the data field, then clears both fields and the pending field. It overrides any write, restore or jump in the same cycle.
- R10: `restore_i` (without `int_ack_i`) loads the saved instruction field into the pending field and the saved data field into the data field. Same-cycle field writes are ignored, and the instruction field changes only at a following jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| pc_i | input | 12 | Current program counter |
| offset_i | input | 7 | In-page offset of the memory reference |
| page_sel_i | input | 1 | 0 = page zero, 1 = current page |
| if_we_i | input | 1 | Write the pending instruction field |
| if_wdata_i | input | 3 | New instruction field value |
| df_we_i | input | 1 | Write the data field |
| df_wdata_i | input | 3 | New data field value |
| jump_i | input | 1 | Jump or call executed; commit the pending field |
| int_ack_i | input | 1 | Interrupt acknowledged |
| restore_i | input | 1 | Reload fields from the save register |
| addr_o | output | 15 | Physical address {field, 12-bit address} |
| addr_valid_o | output | 1 | `addr_o` holds the address of last cycle's request |
| if_o | output | 3 | Current instruction field |
| df_o | output | 3 | Current data field |

## Verification
The bench builds the block with its default widths: a 12-bit native address, a 7-bit offset and a 3-bit field. With these values all eight fields and all 32 pages can be reached by random program counters and field writes within a few thousand cycles. Directed sequences place writes, jumps, interrupt acknowledges and restores in the same cycle as accesses and as each other. This exercises the priority between the strobes and the rule that a request uses the field value held before that cycle's update.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    ACC_DATA  = 1'b0,
    ACC_FETCH = 1'b1
  } acc_e;

  localparam int unsigned DEF_ADDR_W  = 12;
  localparam int unsigned DEF_OFFS_W  = 7;
  localparam int unsigned DEF_FIELD_W = 3;
endpackage

// File: rtl/pg_ea_calc.sv
module pg_ea_calc #(
  parameter int unsigned ADDR_W = pg_pkg::DEF_ADDR_W,
  parameter int unsigned OFFS_W = pg_pkg::DEF_OFFS_W
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic              page_sel_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFFS_W;

  logic [PAGE_W-1:0] page;

  always_comb begin
    page = page_sel_i ? pc_i[ADDR_W-1:OFFS_W] : '0;
    ea_o = {page, offset_i};
  end
endmodule

// File: rtl/pg_field_regs.sv
module pg_field_regs #(
  parameter int unsigned FIELD_W = pg_pkg::DEF_FIELD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               if_we_i,
  input  logic [FIELD_W-1:0] if_wdata_i,
  input  logic               df_we_i,
  input  logic [FIELD_W-1:0] df_wdata_i,
  input  logic               jump_i,
  input  logic               int_ack_i,
  input  logic               restore_i,
  output logic [FIELD_W-1:0] if_o,
  output logic [FIELD_W-1:0] df_o
);
  logic [FIELD_W-1:0] if_q, pend_q, df_q, sav_if_q, sav_df_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_q     <= '0;
      pend_q   <= '0;
      df_q     <= '0;
      sav_if_q <= '0;
      sav_df_q <= '0;
    end else if (int_ack_i) begin
      sav_if_q <= if_q;
      sav_df_q <= df_q;
      if_q     <= '0;
      pend_q   <= '0;
      df_q     <= '0;
    end else begin
      if (jump_i) if_q <= pend_q;
      if (restore_i) begin
        pend_q <= sav_if_q;
        df_q   <= sav_df_q;
      end else begin
        if (if_we_i) pend_q <= if_wdata_i;
        if (df_we_i) df_q   <= df_wdata_i;
      end
    end
  end

  assign if_o = if_q;
  assign df_o = df_q;

  AST_INT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i |=> (if_o == '0) && (df_o == '0)); // R9
  AST_INT_SAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i |=> (sav_if_q == $past(if_o)) && (sav_df_q == $past(df_o))); // R9
  AST_JUMP_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !int_ack_i) |=> if_o == $past(pend_q)); // R8
  AST_IF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !int_ack_i) |=> $stable(if_o)); // R7
  AST_DF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (df_we_i && !int_ack_i && !restore_i) |=> df_o == $past(df_wdata_i)); // R6
  AST_RESTORE_DF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !int_ack_i) |=> df_o == $past(sav_df_q)); // R10
endmodule

// File: rtl/pg_addr_out.sv
module pg_addr_out #(
  parameter int unsigned ADDR_W  = pg_pkg::DEF_ADDR_W,
  parameter int unsigned FIELD_W = pg_pkg::DEF_FIELD_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  pg_pkg::acc_e              acc_i,
  input  logic [FIELD_W-1:0]        if_i,
  input  logic [FIELD_W-1:0]        df_i,
  input  logic [ADDR_W-1:0]         pc_i,
  input  logic [ADDR_W-1:0]         ea_i,
  output logic [FIELD_W+ADDR_W-1:0] addr_o,
  output logic                      valid_o
);
  localparam int unsigned PHYS_W = FIELD_W + ADDR_W;

  logic [PHYS_W-1:0] addr_d;

  always_comb begin
    if (acc_i == pg_pkg::ACC_FETCH) addr_d = {if_i, pc_i};
    else                            addr_d = {df_i, ea_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) addr_o <= addr_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R5
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R5
  AST_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_i == pg_pkg::ACC_FETCH) |=>
      addr_o == {$past(if_i), $past(pc_i)}); // R4
  AST_DATA_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_i == pg_pkg::ACC_DATA) |=>
      addr_o[PHYS_W-1:ADDR_W] == $past(df_i)); // R4
endmodule

// File: rtl/pg_addr_gen.sv
module pg_addr_gen #(
  parameter int unsigned ADDR_W  = pg_pkg::DEF_ADDR_W,
  parameter int unsigned OFFS_W  = pg_pkg::DEF_OFFS_W,
  parameter int unsigned FIELD_W = pg_pkg::DEF_FIELD_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      fetch_i,
  input  logic [ADDR_W-1:0]         pc_i,
  input  logic [OFFS_W-1:0]         offset_i,
  input  logic                      page_sel_i,
  input  logic                      if_we_i,
  input  logic [FIELD_W-1:0]        if_wdata_i,
  input  logic                      df_we_i,
  input  logic [FIELD_W-1:0]        df_wdata_i,
  input  logic                      jump_i,
  input  logic                      int_ack_i,
  input  logic                      restore_i,
  output logic [FIELD_W+ADDR_W-1:0] addr_o,
  output logic                      addr_valid_o,
  output logic [FIELD_W-1:0]        if_o,
  output logic [FIELD_W-1:0]        df_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] ea;
  pg_pkg::acc_e      acc;

  assign acc = pg_pkg::acc_e'(fetch_i);

  pg_ea_calc #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_ea (
    .pc_i       (pc_i),
    .offset_i   (offset_i),
    .page_sel_i (page_sel_i),
    .ea_o       (ea)
  );

  pg_field_regs #(.FIELD_W(FIELD_W)) i_fields (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .if_we_i    (if_we_i),
    .if_wdata_i (if_wdata_i),
    .df_we_i    (df_we_i),
    .df_wdata_i (df_wdata_i),
    .jump_i     (jump_i),
    .int_ack_i  (int_ack_i),
    .restore_i  (restore_i),
    .if_o       (if_o),
    .df_o       (df_o)
  );

  pg_addr_out #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .acc_i   (acc),
    .if_i    (if_o),
    .df_i    (df_o),
    .pc_i    (pc_i),
    .ea_i    (ea),
    .addr_o  (addr_o),
    .valid_o (addr_valid_o)
  );

  AST_PAGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !fetch_i && !page_sel_i) |=>
      (addr_o[ADDR_W-1:OFFS_W] == '0) && (addr_o[OFFS_W-1:0] == $past(offset_i))); // R2
  AST_CUR_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !fetch_i && page_sel_i) |=>
      (addr_o[ADDR_W-1:OFFS_W] == $past(pc_i[ADDR_W-1:OFFS_W])) &&
      (addr_o[OFFS_W-1:0] == $past(offset_i))); // R3
  AST_PAGE_W_OK: assert final (PAGE_W > 0); // R3
endmodule

// File: tb/test_pg_addr_gen.sv
module test_pg_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, fetch_i = 0, page_sel_i = 0;
  logic [11:0] pc_i = '0;
  logic [6:0]  offset_i = '0;
  logic        if_we_i = 0, df_we_i = 0, jump_i = 0, int_ack_i = 0, restore_i = 0;
  logic [2:0]  if_wdata_i = '0, df_wdata_i = '0;
  logic [14:0] addr_o;
  logic        addr_valid_o;
  logic [2:0]  if_o, df_o;

  int checks = 0, failures = 0;

  int m_if, m_pend, m_df, m_sif, m_sdf, m_addr, m_fetch, m_psel, nif;
  bit m_valid;

  always #5 clk_i = ~clk_i;

  pg_addr_gen i_pg_addr_gen (
    .clk_i, .rst_ni, .req_i, .fetch_i, .pc_i, .offset_i, .page_sel_i,
    .if_we_i, .if_wdata_i, .df_we_i, .df_wdata_i, .jump_i, .int_ack_i,
    .restore_i, .addr_o, .addr_valid_o, .if_o, .df_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_if = 0; m_pend = 0; m_df = 0; m_sif = 0; m_sdf = 0;
      m_addr = 0; m_valid = 0; m_fetch = 0; m_psel = 0;
    end else begin
      m_valid = req_i;
      if (req_i) begin
        m_fetch = int'(fetch_i);
        m_psel  = int'(page_sel_i);
        if (fetch_i) m_addr = m_if * 4096 + int'(pc_i);
        else m_addr = m_df * 4096 + (page_sel_i ? (int'(pc_i) / 128) * 128 : 0)
                      + int'(offset_i);
      end
      if (int_ack_i) begin
        m_sif = m_if; m_sdf = m_df; m_if = 0; m_pend = 0; m_df = 0;
      end else begin
        nif = jump_i ? m_pend : m_if;
        if (restore_i) begin
          m_pend = m_sif; m_df = m_sdf;
        end else begin
          if (if_we_i) m_pend = int'(if_wdata_i);
          if (df_we_i) m_df = int'(df_wdata_i);
        end
        m_if = nif;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(addr_valid_o == m_valid, "R5", int'(addr_valid_o), int'(m_valid));
      if (m_valid) begin
        chk(int'(addr_o) / 4096 == m_addr / 4096, "R4", int'(addr_o) / 4096, m_addr / 4096);
        chk(int'(addr_o) % 4096 == m_addr % 4096,
            m_fetch != 0 ? "R4" : (m_psel != 0 ? "R3" : "R2"),
            int'(addr_o) % 4096, m_addr % 4096);
      end
      chk(int'(if_o) == m_if, "R8", int'(if_o), m_if);
      chk(int'(df_o) == m_df, "R6", int'(df_o), m_df);
    end
  end

  task automatic idle();
    req_i = 0; if_we_i = 0; df_we_i = 0; jump_i = 0; int_ack_i = 0; restore_i = 0;
  endtask

  task automatic access(input bit f, input bit ps, input int pc, input int off);
    req_i = 1; fetch_i = f; page_sel_i = ps; pc_i = 12'(pc); offset_i = 7'(off);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(if_o == 0 && df_o == 0, "R1", int'({if_o, df_o}), 0);
    chk(addr_valid_o == 0, "R1", int'(addr_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(addr_valid_o == 0 && if_o == 0, "R1", int'(addr_valid_o), 0);
    access(0, 0, 'h3A7, 'h55);
    @(negedge clk_i); idle();
    chk(addr_o == 15'h0055, "R2", int'(addr_o), 'h55);
    access(0, 1, 'hABC, 'h55);
    @(negedge clk_i); idle();
    chk(addr_o == 15'h0AD5, "R3", int'(addr_o), 'hAD5);
    access(0, 1, 'h07F, 'h01); df_we_i = 1; df_wdata_i = 3;
    @(negedge clk_i); idle();
    chk(addr_o == 15'h0001, "R6", int'(addr_o), 'h1);
    access(0, 0, 'h000, 'h10);
    @(negedge clk_i); idle();
    chk(addr_o == 15'h3010, "R6", int'(addr_o), 'h3010);
    access(1, 0, 'h123, 0); if_we_i = 1; if_wdata_i = 5;
    @(negedge clk_i); idle();
    access(1, 0, 'h124, 0);
    @(negedge clk_i); idle();
    chk(if_o == 0 && addr_o == 15'h0124, "R7", int'(addr_o), 'h124);
    jump_i = 1;
    @(negedge clk_i); idle();
    chk(if_o == 5, "R8", int'(if_o), 5);
    access(1, 0, 'h200, 0);
    @(negedge clk_i); idle();
    chk(addr_o == 15'h5200, "R4", int'(addr_o), 'h5200);
    int_ack_i = 1; df_we_i = 1; df_wdata_i = 6; jump_i = 1; if_we_i = 1; if_wdata_i = 7;
    @(negedge clk_i); idle();
    chk(if_o == 0 && df_o == 0, "R9", int'({if_o, df_o}), 0);
    jump_i = 1;
    @(negedge clk_i); idle();
    chk(if_o == 0, "R9", int'(if_o), 0);
    restore_i = 1; df_we_i = 1; df_wdata_i = 1;
    @(negedge clk_i); idle();
    chk(df_o == 3 && if_o == 0, "R10", int'({if_o, df_o}), 3);
    jump_i = 1;
    @(negedge clk_i); idle();
    chk(if_o == 5, "R10", int'(if_o), 5);
    for (int i = 0; i < 4000; i++) begin
      req_i      = 1'($urandom_range(0, 3) != 0);
      fetch_i    = 1'($urandom);
      page_sel_i = 1'($urandom);
      pc_i       = 12'($urandom);
      offset_i   = 7'($urandom);
      if_we_i    = 1'($urandom_range(0, 5) == 0);
      if_wdata_i = 3'($urandom);
      df_we_i    = 1'($urandom_range(0, 5) == 0);
      df_wdata_i = 3'($urandom);
      jump_i     = 1'($urandom_range(0, 7) == 0);
      int_ack_i  = 1'($urandom_range(0, 15) == 0);
      restore_i  = 1'($urandom_range(0, 15) == 0);
      @(negedge clk_i);
    end
    idle();
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule